// File: doc/BRIEF.md
# Address Offset Adder with Fault Halt

This unit sits between an internal 16-bit address bus and the memory address bus. It holds a small unsigned offset, loaded from the 8-bit data bus. When the offset is applied, the address that memory sees is the internal address plus the zero-extended offset. A separate plus-one control adds a carry-in, so the second byte of a two-byte value can be reached without touching the register that produced the address. The adder is purely combinational, so the memory address follows the internal bus in the same cycle.

A sum that carries past the top address bit has no meaningful next step. The unit treats it as a fatal condition. The carry is captured in a fault flag on the next clock edge. That flag drops the clock-enable output, which halts the system clock. Only the global reset clears the flag. The step-counter reset clears the offset at the end of every instruction, but it does not clear the fault.

Top module: `addr_offset_unit`

## Requirements
- R1: After the global reset (`rst_n` low) the offset is zero, `fault` is 0 and `clk_en` is 1, so with `ofs_apply` = 1 and `plus_one` = 0, `mem_addr` equals `addr_bus`.
- R2: On a rising clock edge with `ofs_load` = 1 and `step_clr` = 0, the offset takes the value of `data_bus`, which is used from the following cycle on. Without `ofs_load` or `step_clr` the offset keeps its value.
- R3: With `ofs_apply` = 1, `mem_addr` = (`addr_bus` + zero-extended offset + `plus_one`) mod 2^16, in the same cycle as the inputs.
- R4: With `ofs_apply` = 0, the offset term is zero and `mem_addr` = `addr_bus` + `plus_one`. The stored offset is kept and returns when `ofs_apply` is set again.
- R5: `plus_one` = 1 adds exactly one to the result whether or not the offset is applied.
- R6: On a rising clock edge with `step_clr` = 1, the offset becomes zero. This takes priority over a simultaneous `ofs_load`.
- R7: When the full sum (address + applied offset + `plus_one`) is 2^16 or more in a cycle, `fault` is 1 and `clk_en` is 0 from the next clock edge. `mem_addr` in the carrying cycle shows the low 16 bits of the sum.
- R8: Once set, `fault` stays 1 and `clk_en` stays 0 whatever the other inputs do, including `step_clr`, until `rst_n` is driven low.
- R9: A sum of exactly 0xFFFF gives no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Global reset, active low, asynchronous |
| ofs_load | input | 1 | Load the offset register from `data_bus` |
| ofs_apply | input | 1 | Add the stored offset to the address |
| plus_one | input | 1 | Carry-in that adds one to the address |
| step_clr | input | 1 | Step-counter reset: clears the offset |
| data_bus | input | 8 | Data bus, the source of the offset |
| addr_bus | input | 16 | Internal address bus |
| mem_addr | output | 16 | Memory address bus |
| fault | output | 1 | Latched carry-out fault |
| clk_en | output | 1 | System clock enable, low while faulted |

## Verification
`mem_addr` is due in the same cycle as its inputs. It is checked 1 ns after the inputs change on the falling edge, well before the next rising edge. A new offset and the fault flag are due one rising edge after the cycle that causes them. The bench updates its model at the rising edge and compares these values at the next mid-cycle sample. It never compares them in the cycle that caused them. The bench covers both results: the offset, through the sum it produces, and the fault and clock-enable pair. It uses directed sums at the 0xFFFF/0x10000 boundary and random cycles weighted toward the top of the address space.

// File: rtl/aou_pkg.sv
package aou_pkg;

  // Width of one ripple slice of the address adder.
  localparam int SLICE_W = 4;

  // Adds one slice with its carry-in; the top bit of the result is the slice carry-out.
  function automatic logic [SLICE_W:0] slice_add(
    input logic [SLICE_W-1:0] a,
    input logic [SLICE_W-1:0] b,
    input logic               cin
  );
    slice_add = {1'b0, a} + {1'b0, b} + {{SLICE_W{1'b0}}, cin};
  endfunction

  // Zero-extends an offset to address width, or yields zero when not applied.
  function automatic logic [31:0] gated_offset(
    input logic [31:0] ofs,
    input logic        apply
  );
    gated_offset = apply ? ofs : 32'd0;
  endfunction

endpackage

// File: rtl/aou_offset_reg.sv
module aou_offset_reg #(
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [OFS_W-1:0] d,
  output logic [OFS_W-1:0] q
);

  // Step clear wins over load; both act on the rising edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (clr)  q <= '0;
    else if (load) q <= d;
  end

endmodule

// File: rtl/aou_adder.sv
module aou_adder
  import aou_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 8
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFS_W-1:0]  ofs,
  input  logic              apply,
  input  logic              cin,
  output logic [ADDR_W-1:0] sum,
  output logic              carry_out
);

  // ADDR_W must be a multiple of SLICE_W.
  localparam int NSLICE = ADDR_W / SLICE_W;

  logic [31:0]       ofs_wide;
  logic [ADDR_W-1:0] opnd;
  logic [NSLICE:0]   cy;

  assign ofs_wide = gated_offset({{(32-OFS_W){1'b0}}, ofs}, apply);
  assign opnd     = ofs_wide[ADDR_W-1:0];
  assign cy[0]    = cin;

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    logic [SLICE_W:0] r;
    assign r = slice_add(base[s*SLICE_W +: SLICE_W], opnd[s*SLICE_W +: SLICE_W], cy[s]);
    assign sum[s*SLICE_W +: SLICE_W] = r[SLICE_W-1:0];
    assign cy[s+1] = r[SLICE_W];
  end

  assign carry_out = cy[NSLICE];

  // The offset register is narrower than the address, so the upper bits of the wide
  // offset are zero whenever the widths are consistent.
  logic unused_hi;
  assign unused_hi = ^ofs_wide[31:ADDR_W];

endmodule

// File: rtl/aou_fault_latch.sv
module aou_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic carry,
  output logic trip,
  output logic fault,
  output logic clk_en
);

  // A new fault event: a carry while not yet faulted.
  assign trip = carry & ~fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    fault <= 1'b0;
    else if (trip) fault <= 1'b1;
  end

  assign clk_en = ~fault;

endmodule

// File: rtl/addr_offset_unit.sv
module addr_offset_unit #(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ofs_load,
  input  logic              ofs_apply,
  input  logic              plus_one,
  input  logic              step_clr,
  input  logic [OFS_W-1:0]  data_bus,
  input  logic [ADDR_W-1:0] addr_bus,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              fault,
  output logic              clk_en
);

  // Internal events brought out by name for the checker.
  logic [OFS_W-1:0] ofs_q;
  logic             carry_out;
  logic             trip;

  aou_offset_reg #(.OFS_W(OFS_W)) u_ofs (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (step_clr),
    .load  (ofs_load),
    .d     (data_bus),
    .q     (ofs_q)
  );

  aou_adder #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_add (
    .base      (addr_bus),
    .ofs       (ofs_q),
    .apply     (ofs_apply),
    .cin       (plus_one),
    .sum       (mem_addr),
    .carry_out (carry_out)
  );

  aou_fault_latch u_flt (
    .clk    (clk),
    .rst_n  (rst_n),
    .carry  (carry_out),
    .trip   (trip),
    .fault  (fault),
    .clk_en (clk_en)
  );

endmodule

// File: rtl/aou_checker.sv
module aou_checker #(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ofs_load,
  input logic              ofs_apply,
  input logic              plus_one,
  input logic              step_clr,
  input logic [OFS_W-1:0]  data_bus,
  input logic [ADDR_W-1:0] addr_bus,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              fault,
  input logic              clk_en,
  input logic [OFS_W-1:0]  ofs_q,
  input logic              carry_out,
  input logic              trip
);

  // R2
  ofs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs_load && !step_clr) |=> (ofs_q == $past(data_bus)));

  // R2
  ofs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ofs_load && !step_clr) |=> $stable(ofs_q));

  // R6
  step_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_clr |=> (ofs_q == '0));

  // R4
  no_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ofs_apply && !plus_one) |-> (mem_addr == addr_bus));

  // R7
  fault_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carry_out |=> fault);

  // R7
  fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> (!clk_en && $past(trip)));

  // R8
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (fault && !clk_en));

endmodule

bind addr_offset_unit aou_checker #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ofs_load  (ofs_load),
  .ofs_apply (ofs_apply),
  .plus_one  (plus_one),
  .step_clr  (step_clr),
  .data_bus  (data_bus),
  .addr_bus  (addr_bus),
  .mem_addr  (mem_addr),
  .fault     (fault),
  .clk_en    (clk_en),
  .ofs_q     (ofs_q),
  .carry_out (carry_out),
  .trip      (trip)
);

// File: tb/test_addr_offset_unit.sv
`timescale 1ns/1ps
module test_addr_offset_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ofs_load, ofs_apply, plus_one, step_clr;
  logic [7:0]  data_bus;
  logic [15:0] addr_bus;
  logic [15:0] mem_addr;
  logic        fault, clk_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int m_ofs   = 0;
  bit m_fault = 0;

  always #2.5 clk = ~clk;

  addr_offset_unit i_addr_offset_unit (
    .clk(clk), .rst_n(rst_n), .ofs_load(ofs_load), .ofs_apply(ofs_apply),
    .plus_one(plus_one), .step_clr(step_clr), .data_bus(data_bus),
    .addr_bus(addr_bus), .mem_addr(mem_addr), .fault(fault), .clk_en(clk_en)
  );

  // Full sum as an integer, including any carry past bit 15.
  function automatic int full_sum(int a, int o, bit ap, bit p1);
    int t = a;
    if (ap) t = t + o;
    if (p1) t = t + 1;
    return t;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Called just after a falling edge; returns just after the next falling edge.
  task automatic step(string tag, bit ld, bit ap, bit p1, bit clr, int d, int a);
    int s;
    ofs_load = ld; ofs_apply = ap; plus_one = p1; step_clr = clr;
    data_bus = d[7:0]; addr_bus = a[15:0];
    #1;
    s = full_sum(a & 16'hFFFF, m_ofs, ap, p1);
    chk(tag, "mem_addr", int'(mem_addr), s % 65536);
    chk(tag, "fault", int'(fault), int'(m_fault));
    chk(tag, "clk_en", int'(clk_en), int'(!m_fault));
    @(posedge clk);
    if (s >= 65536) m_fault = 1;
    if (clr) m_ofs = 0;
    else if (ld) m_ofs = d & 8'hFF;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ofs_load = 0; ofs_apply = 0; plus_one = 0; step_clr = 0;
    data_bus = 8'hA5; addr_bus = 16'hFFFF;
    repeat (2) @(negedge clk);
    m_ofs = 0; m_fault = 0;
    rst_n = 1'b1;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();

    // R1: reset state, offset zero
    step("R1", 0, 1, 0, 0, 8'h00, 16'h1234);
    // R2: load an offset, then R3 uses it
    step("R2", 1, 0, 0, 0, 8'h5A, 16'h1000);
    step("R3", 0, 1, 0, 0, 8'h11, 16'h1000);
    step("R3", 0, 1, 0, 0, 8'h22, 16'h7FF0);
    // R4: offset ignored when not applied, but retained
    step("R4", 0, 0, 0, 0, 8'h33, 16'h1000);
    step("R4", 0, 1, 0, 0, 8'h33, 16'h1000);
    // R5: plus one with and without the offset
    step("R5", 0, 0, 1, 0, 8'h00, 16'h1000);
    step("R5", 0, 1, 1, 0, 8'h00, 16'h1000);
    // R6: clear wins over load
    step("R6", 1, 1, 0, 1, 8'h77, 16'h2000);
    step("R6", 0, 1, 0, 0, 8'h00, 16'h2000);
    // R9: exact top of range does not fault
    step("R9", 1, 0, 0, 0, 8'hFF, 16'h0000);
    step("R9", 0, 1, 0, 0, 8'h00, 16'hFF00);
    step("R9", 0, 1, 0, 0, 8'h00, 16'hFF00);
    // R7: one more carries; wrap shown, fault next cycle
    step("R7", 0, 1, 1, 0, 8'h00, 16'hFF00);
    step("R7", 0, 0, 0, 0, 8'h00, 16'h0100);
    // R8: fault held against clear, loads and quiet sums
    step("R8", 1, 1, 0, 1, 8'h10, 16'h0000);
    step("R8", 0, 0, 0, 0, 8'h00, 16'h0001);
    step("R8", 0, 1, 1, 0, 8'h00, 16'h0002);
    do_reset();
    step("R8", 0, 1, 0, 0, 8'h00, 16'h4321);
    // R7: plus one alone carries at 0xFFFF
    step("R7", 0, 0, 1, 0, 8'h00, 16'hFFFF);
    step("R7", 0, 0, 0, 0, 8'h00, 16'h0000);
    do_reset();
    step("R1", 0, 1, 0, 0, 8'h00, 16'hFFFF);

    // Random phase, addresses biased toward the top of the range.
    for (int i = 0; i < 600; i++) begin
      int a;
      a = $urandom_range(0, 65535);
      if ($urandom_range(0, 3) == 0) a = 16'hFF00 | $urandom_range(0, 255);
      step("R3", $urandom_range(0, 2) == 0, $urandom_range(0, 3) != 0,
           $urandom_range(0, 3) == 0, $urandom_range(0, 7) == 0,
           $urandom_range(0, 255), a);
      if (m_fault && $urandom_range(0, 3) == 0) do_reset();
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule